// File: doc/BRIEF.md
# Serial Peripheral Frame Master (clock idle low, shift on rise, capture on fall)

This block is a synchronous serial master that moves one data word per frame in each direction. Words to send are written into a small transmit FIFO. While the block is enabled and that FIFO holds data, the block pulls its active-low select line down. It then clocks the word out MSB first on the data-out line and samples the data-in line into a receive FIFO. The serial clock idles low. Outgoing bits change on rising clock edges and incoming bits are captured on falling edges.

The word length is programmable from 4 to 16 bits. The serial clock period is set at build time by an even divider of system clocks. If more words are waiting when a word completes, the select line stays low and the next word follows at the normal bit pitch. The frame closes one full serial clock period after the final capture. A received word that finds the receive FIFO full is discarded, and this is recorded in a sticky overrun flag.

Top module: `spi_frame_master`

## Requirements
- R1: Outside a frame (select high) the serial clock and data-out are low, and from reset onwards the clock output enable is always high (master drives the clock pad).
- R2: A frame starts, by driving select low, only while `enable` is high and the transmit FIFO is non-empty. With `enable` low, no frame starts even when data is queued.
- R3: The first rising serial clock edge comes exactly SCLK_DIV/2 system clocks after select falls, and the word's MSB appears on data-out at that same edge.
- R4: The serial clock is high and low for SCLK_DIV/2 system clocks each. Data-out changes only at a rising serial clock edge or when select returns high. Data-in is captured at falling edges.
- R5: A frame word is `word_len`+1 bits, taking the low bits of the written word, MSB first. `word_len` codes 0, 1 and 2 are treated as code 3 (4 bits).
- R6: Select returns high exactly SCLK_DIV system clocks after the last falling edge of the final word, and data-out is low from then on.
- R7: If the transmit FIFO is non-empty at the last falling edge of a word, select stays low. The next word's first rising edge then follows the previous rising edge by exactly SCLK_DIV system clocks.
- R8: Each received word enters the receive FIFO right-aligned, with all unused upper bits zero.
- R9: `busy` is high exactly while select is low.
- R10: The word length in use is taken from `word_len` only while idle. Changes to `word_len` while busy do not affect words in the running frame.
- R11: A word received while the receive FIFO is full is dropped and sets `overrun`. `overrun` stays set until an `ovr_clr` pulse. If a drop and a clear occur in the same cycle, the flag stays set.
- R12: `tx_ready` is low exactly when the transmit FIFO (depth FIFO_DEPTH) is full. `rx_valid` is high when the receive FIFO holds data. Both FIFOs are first-in first-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new frames to start and words to chain |
| word_len | input | 4 | Word length minus one (3..15; lower codes act as 3) |
| tx_valid | input | 1 | Write strobe for the transmit FIFO |
| tx_data | input | 16 | Word to transmit (low bits used) |
| tx_ready | output | 1 | Transmit FIFO has space |
| rx_valid | output | 1 | Receive FIFO holds a word |
| rx_data | output | 16 | Oldest received word, right-aligned |
| rx_pop | input | 1 | Removes the oldest received word when rx_valid is high |
| ovr_clr | input | 1 | Clears the overrun flag |
| overrun | output | 1 | Sticky: a received word was dropped |
| busy | output | 1 | A frame is in progress |
| sclk | output | 1 | Serial clock |
| sclk_oe | output | 1 | Serial clock pad output enable |
| fss_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench measures, in system clocks, the lead from select falling to the first rising edge, every high time and every rise-to-rise pitch, including the gap across a word boundary. It also measures the tail from the last capture to select rising. A design with an off-by-one counter or an extra idle half period between chained words fails these measurements. Batches of one to four queued words must each produce exactly one frame, so a design that lets select bounce between words is caught. The bench changes `word_len` mid-frame, so a design that picks up the new length too early shifts the wrong number of bits. It also drives short length codes that must widen to four bits. An overrun sequence fills the receive FIFO and then checks that the extra word is absent, not written over the oldest one, and that the flag holds until it is cleared.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned LEN_W      = 4;
    localparam logic [3:0]  MIN_LEN_M1 = 4'd3;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LEAD,
        PH_SHIFT,
        PH_TRAIL
    } phase_e;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] code);
        return (code < MIN_LEN_M1) ? MIN_LEN_M1 : code;
    endfunction

endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [W-1:0] mem [DEPTH];

    logic do_push, do_pop;

    assign empty   = (q.cnt == '0);
    assign full    = (q.cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[q.rp];

    always_comb begin
        d = q;
        if (do_push) begin
            d.wp = (q.wp == LAST) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == LAST) ? '0 : q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[q.wp] <= wdata;
        end
    end

endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
    import spi_fm_pkg::*;
#(
    parameter int unsigned HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [LEN_W-1:0]  len_req,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              fss_n,
    output logic              mosi,
    output logic              busy,
    output logic [LEN_W-1:0]  cur_len
);
    localparam int unsigned CW = (2 * HALF > 2) ? $clog2(2 * HALF) : 1;
    localparam logic [CW-1:0] HALF_END  = CW'(HALF - 1);
    localparam logic [CW-1:0] TRAIL_END = CW'(2 * HALF - 1);

    typedef struct packed {
        phase_e             ph;
        logic [CW-1:0]      cnt;
        logic [LEN_W-1:0]   len_m1;
        logic [LEN_W-1:0]   bitn;
        logic [WORD_W-1:0]  tsh;
        logic [WORD_W-1:0]  rsh;
        logic               sclk;
        logic               fss_n;
        logic               mosi;
    } eng_t;

    eng_t q, d;

    logic              half_done;
    logic              tail_done;
    logic              can_chain;
    logic [WORD_W-1:0] rx_next;

    assign half_done = (q.cnt == HALF_END);
    assign tail_done = (q.cnt == TRAIL_END);
    assign can_chain = enable && !tx_empty;
    assign rx_next   = {q.rsh[WORD_W-2:0], miso};

    always_comb begin
        d       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_word = rx_next;

        // phase-local timer: wraps each half period, or after a full period in the tail
        if (q.ph == PH_IDLE) begin
            d.cnt = '0;
        end else if ((q.ph == PH_TRAIL) ? tail_done : half_done) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end

        unique case (q.ph)
            PH_IDLE: begin
                d.len_m1 = clamp_len(len_req);
                if (can_chain) begin
                    tx_pop  = 1'b1;
                    d.tsh   = tx_word;
                    d.rsh   = '0;
                    d.bitn  = '0;
                    d.fss_n = 1'b0;
                    d.ph    = PH_LEAD;
                end
            end

            PH_LEAD: begin
                if (half_done) begin
                    d.sclk = 1'b1;
                    d.mosi = q.tsh[q.len_m1];
                    d.tsh  = q.tsh << 1;
                    d.ph   = PH_SHIFT;
                end
            end

            PH_SHIFT: begin
                if (half_done) begin
                    if (q.sclk) begin
                        // falling edge: capture
                        d.sclk = 1'b0;
                        d.rsh  = rx_next;
                        if (q.bitn == q.len_m1) begin
                            rx_push = 1'b1;
                            d.rsh   = '0;
                            d.bitn  = '0;
                            if (can_chain) begin
                                tx_pop = 1'b1;
                                d.tsh  = tx_word;
                            end else begin
                                d.ph = PH_TRAIL;
                            end
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                        end
                    end else begin
                        // rising edge: launch
                        d.sclk = 1'b1;
                        d.mosi = q.tsh[q.len_m1];
                        d.tsh  = q.tsh << 1;
                    end
                end
            end

            PH_TRAIL: begin
                if (tail_done) begin
                    d.fss_n = 1'b1;
                    d.mosi  = 1'b0;
                    d.ph    = PH_IDLE;
                end
            end

            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.ph     <= PH_IDLE;
            q.len_m1 <= MIN_LEN_M1;
            q.fss_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk    = q.sclk;
    assign fss_n   = q.fss_n;
    assign mosi    = q.mosi;
    assign busy    = (q.ph != PH_IDLE);
    assign cur_len = q.len_m1;

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
    import spi_fm_pkg::*;
#(
    parameter int unsigned SCLK_DIV   = 8,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic [3:0]  word_len,
    input  logic        tx_valid,
    input  logic [15:0] tx_data,
    output logic        tx_ready,
    output logic        rx_valid,
    output logic [15:0] rx_data,
    input  logic        rx_pop,
    input  logic        ovr_clr,
    output logic        overrun,
    output logic        busy,
    output logic        sclk,
    output logic        sclk_oe,
    output logic        fss_n,
    output logic        mosi,
    input  logic        miso
);
    localparam int unsigned HALF = SCLK_DIV / 2;

    typedef struct packed {
        logic ovr;
    } top_t;

    top_t q, d;

    logic              tx_full, tx_empty, tx_pop;
    logic [WORD_W-1:0] tx_word;
    logic              rx_full, rx_empty, rx_push;
    logic [WORD_W-1:0] rx_word;
    logic [LEN_W-1:0]  cur_len;

    spi_fm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_valid),
        .wdata (tx_data),
        .pop   (tx_pop),
        .rdata (tx_word),
        .empty (tx_empty),
        .full  (tx_full)
    );

    spi_fm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_word),
        .pop   (rx_pop),
        .rdata (rx_data),
        .empty (rx_empty),
        .full  (rx_full)
    );

    spi_fm_engine #(.HALF(HALF)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .len_req  (word_len),
        .tx_empty (tx_empty),
        .tx_word  (tx_word),
        .tx_pop   (tx_pop),
        .rx_push  (rx_push),
        .rx_word  (rx_word),
        .miso     (miso),
        .sclk     (sclk),
        .fss_n    (fss_n),
        .mosi     (mosi),
        .busy     (busy),
        .cur_len  (cur_len)
    );

    always_comb begin
        d = q;
        if (ovr_clr) begin
            d.ovr = 1'b0;
        end
        if (rx_push && rx_full) begin
            d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign overrun  = q.ovr;
    assign tx_ready = !tx_full;
    assign rx_valid = !rx_empty;
    assign sclk_oe  = 1'b1;

endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fss_n,
    input logic       sclk,
    input logic       sclk_oe,
    input logic       mosi,
    input logic       busy,
    input logic [3:0] cur_len,
    input logic       overrun,
    input logic       ovr_clr,
    input logic       rx_push,
    input logic       rx_full
);

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fss_n |-> (!sclk && !mosi));

    assert_clk_pad_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_oe);

    assert_rise_inside_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !fss_n);

    assert_mosi_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> ($rose(sclk) || $rose(fss_n)));

    assert_select_closes_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fss_n) |-> !sclk);

    assert_busy_tracks_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !fss_n);

    assert_len_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(cur_len)));

    assert_len_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_len >= 4'd3);

    assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    assert_overrun_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> overrun);

    assert_overrun_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !(rx_push && rx_full)) |=> !overrun);

endmodule

bind spi_frame_master spi_frame_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fss_n   (fss_n),
    .sclk    (sclk),
    .sclk_oe (sclk_oe),
    .mosi    (mosi),
    .busy    (busy),
    .cur_len (cur_len),
    .overrun (overrun),
    .ovr_clr (ovr_clr),
    .rx_push (rx_push),
    .rx_full (rx_full)
);

// File: tb/spi_frame_master_tb.sv
module spi_frame_master_tb;

    localparam int HALF  = 4;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [3:0]  word_len = 4'd7;
    logic        tx_valid = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_ready;
    logic        rx_valid;
    logic [15:0] rx_data;
    logic        rx_pop = 1'b0;
    logic        ovr_clr = 1'b0;
    logic        overrun;
    logic        busy;
    logic        sclk;
    logic        sclk_oe;
    logic        fss_n;
    logic        mosi;
    logic        miso = 1'b0;

    always #2.5 clk = ~clk;

    spi_frame_master #(.SCLK_DIV(2 * HALF), .FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .word_len(word_len),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop),
        .ovr_clr(ovr_clr), .overrun(overrun), .busy(busy),
        .sclk(sclk), .sclk_oe(sclk_oe), .fss_n(fss_n), .mosi(mosi), .miso(miso)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] lmask(input int bits);
        return (bits >= 16) ? 16'hFFFF : 16'((32'd1 << bits) - 1);
    endfunction

    function automatic int eff_bits(input logic [3:0] code);
        return (code < 4'd3) ? 4 : int'(code) + 1;
    endfunction

    // ---------------- bus monitors (time in system clocks) ----------------
    int cyc = 0;
    always @(negedge clk) cyc++;

    int frames = 0;
    int t_fall = -1000;
    int t_rise = -2000;
    int t_cap  = 0;
    int idle_bad = 0;
    int busy_bad = 0;
    int cur_bits = 8;

    always @(negedge fss_n) begin
        frames++;
        t_fall = cyc;
    end

    always @(posedge sclk) begin
        if (t_fall > t_rise)
            chk(cyc - t_fall == HALF, "R3 lead", cyc - t_fall, HALF);
        else
            chk(cyc - t_rise == 2 * HALF, "R4/R7 pitch", cyc - t_rise, 2 * HALF);
        t_rise = cyc;
    end

    always @(posedge fss_n) begin
        if (frames > 0)
            chk(cyc - t_cap == 2 * HALF, "R6 tail", cyc - t_cap, 2 * HALF);
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (fss_n && (sclk || mosi)) idle_bad++;
            if (!sclk_oe) idle_bad++;
            if (busy == fss_n) busy_bad++;
        end
    end

    // data-out capture (receiver side) on falling edges
    logic [15:0] cap_sh = '0;
    int cap_n = 0;
    logic [15:0] cap_q[$];
    always @(negedge sclk) begin
        if (t_rise >= 0) begin
            chk(cyc - t_rise == HALF, "R4 high time", cyc - t_rise, HALF);
        end
        t_cap = cyc;
        cap_sh = {cap_sh[14:0], mosi};
        cap_n++;
        if (cap_n == cur_bits) begin
            cap_q.push_back(cap_sh & lmask(cur_bits));
            cap_n = 0;
            cap_sh = '0;
        end
    end

    // slave model: drives data-in on rising edges
    logic [15:0] miso_q[$];
    logic [15:0] sl_word = '0;
    int sl_n = 0;
    always @(posedge sclk) begin
        if (sl_n == 0) sl_word = (miso_q.size() > 0) ? miso_q.pop_front() : 16'h0;
        miso <= sl_word[cur_bits - 1 - sl_n];
        sl_n++;
        if (sl_n == cur_bits) sl_n = 0;
    end

    logic [15:0] exp_tx[$];
    logic [15:0] exp_rx[$];

    // ---------------- tasks ----------------
    task automatic push_word(input logic [15:0] tw, input logic [15:0] sw, input bit keep_rx);
        @(negedge clk);
        chk(tx_ready, "R12 tx_ready", int'(tx_ready), 1);
        tx_valid = 1'b1;
        tx_data  = tw;
        miso_q.push_back(sw);
        exp_tx.push_back(tw & lmask(cur_bits));
        if (keep_rx) exp_rx.push_back(sw & lmask(cur_bits));
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_caps();
        chk(cap_q.size() == exp_tx.size(), "R5 word count", cap_q.size(), exp_tx.size());
        while (exp_tx.size() > 0 && cap_q.size() > 0) begin
            logic [15:0] e, a;
            e = exp_tx.pop_front();
            a = cap_q.pop_front();
            chk(a == e, "R5 data-out word", a, e);
        end
        exp_tx.delete();
        cap_q.delete();
    endtask

    task automatic drain();
        while (exp_rx.size() > 0) begin
            logic [15:0] e;
            e = exp_rx.pop_front();
            @(negedge clk);
            chk(rx_valid, "R12 rx_valid", int'(rx_valid), 1);
            chk(rx_data == e, "R8 received word", rx_data, e);
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
        @(negedge clk);
        chk(!rx_valid, "R12 rx empty", int'(rx_valid), 0);
    endtask

    task automatic run_batch(input int n, input logic [3:0] code, input bit keep_rx);
        int f0;
        @(negedge clk);
        word_len = code;
        cur_bits = eff_bits(code);
        f0 = frames;
        for (int i = 0; i < n; i++) push_word(16'($urandom), 16'($urandom), keep_rx);
        while (!busy) @(negedge clk);
        word_len = code ^ 4'h5;   // R10: must not affect the running frame
        wait_idle();
        chk(frames - f0 == 1, "R7 one frame per batch", frames - f0, 1);
        check_caps();
    endtask

    // ---------------- main ----------------
    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fss_n == 1'b1, "R1 reset select", fss_n, 1);
        chk(sclk == 1'b0, "R1 reset clock", sclk, 0);
        chk(mosi == 1'b0, "R1 reset data-out", mosi, 0);
        chk(sclk_oe == 1'b1, "R1 clock enable", sclk_oe, 1);
        chk(!busy, "R9 reset busy", busy, 0);
        chk(!rx_valid, "R12 reset rx", rx_valid, 0);
        chk(!overrun, "R11 reset overrun", overrun, 0);
        chk(tx_ready, "R12 reset tx_ready", tx_ready, 1);

        // R2: disabled with queued words; short code 1 widens to 4 bits (R5)
        word_len = 4'd1;
        cur_bits = 4;
        for (int i = 0; i < DEPTH; i++) push_word(16'hFFF0 | 16'(i * 5 + 3), 16'h00A0 | 16'(i + 9), 1'b1);
        chk(!tx_ready, "R12 tx full", tx_ready, 0);
        repeat (60) @(negedge clk);
        chk(frames == 0, "R2 no frame while disabled", frames, 0);
        chk(fss_n == 1'b1, "R2 select idle while disabled", fss_n, 1);
        enable = 1'b1;
        wait_idle();
        chk(frames == 1, "R7 chained words one frame", frames, 1);
        check_caps();
        drain();

        // full length, single word
        run_batch(1, 4'd15, 1'b1);
        drain();

        // R11: fill receive FIFO, then one more word is dropped
        run_batch(DEPTH, 4'd9, 1'b1);
        chk(!overrun, "R11 no overrun at full", overrun, 0);
        run_batch(1, 4'd9, 1'b0);
        chk(overrun, "R11 overrun set", overrun, 1);
        repeat (20) @(negedge clk);
        chk(overrun, "R11 overrun sticky", overrun, 1);
        drain();
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        @(negedge clk);
        chk(!overrun, "R11 overrun cleared", overrun, 0);

        // constrained random batches
        for (int b = 0; b < 30; b++) begin
            run_batch(1 + int'($urandom % DEPTH), 4'($urandom), 1'b1);
            drain();
        end

        chk(idle_bad == 0, "R1 idle lines", idle_bad, 0);
        chk(busy_bad == 0, "R9 busy vs select", busy_bad, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule